// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block refills a page translation cache. It runs only after a virtual address has missed in both the block translation cache and the page translation cache. It latches the 32-bit virtual address and the segment table base, then reads two descriptors from main memory. The first read fetches the segment descriptor. The second read fetches the page descriptor from the page table that the segment descriptor points to. When both descriptors are valid, the walker returns the physical frame number and the attribute field, ready to be written into the page translation cache. When either descriptor is invalid, the walker ends with a fault code that names the level that failed.

Every descriptor read is marked cache-inhibited, so it goes straight to memory. Pages are 4 KB, so the low 12 address bits never take part in the walk. The walker handles one walk at a time. The memory port has a valid/ready request and a single-beat response strobe, and the walker waits for each response for as long as it takes.

Top module: `table_walker`

## Requirements
- R1: A walk is accepted on a clock edge only when `walk_req_i`, `blk_miss_i` and `pg_miss_i` are all high and the walker is idle. If either translation cache hit (its miss input is low), no walk starts and no memory request appears.
- R2: After reset, `busy_o`, `mem_req_valid_o`, `done_o` and `fault_o` are low. `busy_o` rises in the cycle after a walk is accepted. It stays high up to and including the cycle in which `done_o` or `fault_o` pulses, and is low in the cycle after that.
- R3: The first read goes to the segment table base plus 4 times the segment index, where the segment index is VA[31:22]. The addition wraps at 32 bits.
- R4: The second read goes to {segment descriptor[31:12], 12'h000} plus 4 times the page index, where the page index is VA[21:12]. Bits 11:1 of the segment descriptor are ignored.
- R5: A walk that reaches the page level makes exactly two reads: the segment descriptor first, then the page descriptor. A walk that faults at the segment level makes exactly one read.
- R6: `mem_req_nocache_o` is high on every request, so that no descriptor read looks up or allocates into a cache.
- R7: While `mem_req_valid_o` is high and `mem_req_ready_i` is low, the request stays asserted and its address does not change.
- R8: If bit 0 (valid) of the segment descriptor is 0, the walk ends with `fault_o` high for one cycle, `fault_code_o` = 1 and no `done_o`.
- R9: If bit 0 of the page descriptor is 0, the walk ends with `fault_o` high for one cycle, `fault_code_o` = 2 and no `done_o`.
- R10: On success, `done_o` pulses for one cycle with `fault_code_o` = 0. In that cycle `pfn_o` equals page descriptor[31:12] and `attr_o` equals page descriptor[11:1].
- R11: A new walk request that arrives while a walk is in progress is ignored. The walk in progress keeps its own addresses and result.
- R12: A response strobe that arrives while the walker is idle is ignored: no `busy_o`, `done_o` or `fault_o` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| walk_req_i | input | 1 | Request to resolve `va_i` |
| blk_miss_i | input | 1 | Block translation cache missed |
| pg_miss_i | input | 1 | Page translation cache missed |
| va_i | input | 32 | Virtual address to translate |
| seg_base_i | input | 32 | Segment table base address |
| busy_o | output | 1 | A walk is in progress |
| done_o | output | 1 | One-cycle pulse: translation resolved |
| fault_o | output | 1 | One-cycle pulse: walk ended in a fault |
| fault_code_o | output | 2 | 0 none, 1 invalid segment descriptor, 2 invalid page descriptor |
| pfn_o | output | 20 | Physical frame number, valid with `done_o` |
| attr_o | output | 11 | Page attributes, valid with `done_o` |
| mem_req_valid_o | output | 1 | Descriptor read request |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_addr_o | output | 32 | Descriptor byte address |
| mem_req_nocache_o | output | 1 | Cache-inhibit mark on the request |
| mem_rsp_valid_i | input | 1 | Read data strobe |
| mem_rsp_data_i | input | 32 | Read descriptor |

## Verification
The assertions assume that memory never returns a response without a read having been accepted. They also assume that the miss inputs are only meaningful together with a walk request. The bench's memory model keeps to both rules: it raises the response strobe exactly once for each accepted request, after a programmed delay, and it holds ready low for a programmed number of cycles so that the request-hold property is exercised. Spurious strobes are sent only while the walker is idle, which is the case that the idle-stays-idle property covers.

// File: rtl/tw_pkg.sv
package tw_pkg;
    parameter int VA_W   = 32;
    parameter int PA_W   = 32;
    parameter int OFS_W  = 12;
    parameter int IDX_W  = 10;
    parameter int DSZ_LG = 2;

    localparam int PFN_W  = PA_W - OFS_W;
    localparam int ATTR_W = OFS_W - 1;
    localparam int DESC_W = PFN_W + ATTR_W + 1;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SEG_REQ, ST_SEG_WAIT, ST_PG_REQ, ST_PG_WAIT, ST_FIN
    } walk_st_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_SEG  = 2'd1,
        FLT_PAGE = 2'd2
    } flt_e;

    typedef struct packed {
        logic [PFN_W-1:0]  frame;
        logic [ATTR_W-1:0] attr;
        logic              ok;
    } desc_t;

    function automatic logic [IDX_W-1:0] seg_idx(input logic [VA_W-1:0] va);
        return va[VA_W-1 -: IDX_W];
    endfunction

    function automatic logic [IDX_W-1:0] pg_idx(input logic [VA_W-1:0] va);
        return va[OFS_W +: IDX_W];
    endfunction

    function automatic logic [PA_W-1:0] desc_addr(input logic [PA_W-1:0] base,
                                                  input logic [IDX_W-1:0] idx);
        return base + (PA_W'(idx) << DSZ_LG);
    endfunction
endpackage

// File: rtl/tw_ctrl.sv
module tw_ctrl
    import tw_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start_ok,
    input  logic     req_ready,
    input  logic     rsp_valid,
    input  logic     rsp_ok,
    output walk_st_e st
);
    walk_st_e nxt;

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:     if (start_ok)  nxt = ST_SEG_REQ;
            ST_SEG_REQ:  if (req_ready) nxt = ST_SEG_WAIT;
            ST_SEG_WAIT: if (rsp_valid) nxt = rsp_ok ? ST_PG_REQ : ST_FIN;
            ST_PG_REQ:   if (req_ready) nxt = ST_PG_WAIT;
            ST_PG_WAIT:  if (rsp_valid) nxt = ST_FIN;
            ST_FIN:                     nxt = ST_IDLE;
            default:                    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= nxt;
    end
endmodule

// File: rtl/tw_addr.sv
module tw_addr
    import tw_pkg::*;
(
    input  walk_st_e          st,
    input  logic [VA_W-1:0]   va,
    input  logic [PA_W-1:0]   seg_base,
    input  logic [PFN_W-1:0]  pt_frame,
    output logic [PA_W-1:0]   addr
);
    logic [PA_W-1:0] pt_base;

    assign pt_base = {pt_frame, {OFS_W{1'b0}}};

    always_comb begin
        if (st == ST_PG_REQ) addr = desc_addr(pt_base, pg_idx(va));
        else                 addr = desc_addr(seg_base, seg_idx(va));
    end
endmodule

// File: rtl/tw_result.sv
module tw_result
    import tw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_ok,
    input  walk_st_e          st,
    input  logic              rsp_valid,
    input  desc_t             rsp_desc,
    input  logic [VA_W-1:0]   va_in,
    input  logic [PA_W-1:0]   base_in,
    output logic [VA_W-1:0]   va_q,
    output logic [PA_W-1:0]   base_q,
    output logic [PFN_W-1:0]  pt_frame_q,
    output logic [PFN_W-1:0]  pfn_q,
    output logic [ATTR_W-1:0] attr_q,
    output flt_e              code_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            va_q       <= '0;
            base_q     <= '0;
            pt_frame_q <= '0;
            pfn_q      <= '0;
            attr_q     <= '0;
            code_q     <= FLT_NONE;
        end else if (start_ok) begin
            va_q   <= va_in;
            base_q <= base_in;
            code_q <= FLT_NONE;
        end else if (rsp_valid && st == ST_SEG_WAIT) begin
            pt_frame_q <= rsp_desc.frame;
            if (!rsp_desc.ok) code_q <= FLT_SEG;
        end else if (rsp_valid && st == ST_PG_WAIT) begin
            pfn_q  <= rsp_desc.frame;
            attr_q <= rsp_desc.attr;
            if (!rsp_desc.ok) code_q <= FLT_PAGE;
        end
    end
endmodule

// File: rtl/table_walker.sv
module table_walker
    import tw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              walk_req_i,
    input  logic              blk_miss_i,
    input  logic              pg_miss_i,
    input  logic [VA_W-1:0]   va_i,
    input  logic [PA_W-1:0]   seg_base_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              fault_o,
    output logic [1:0]        fault_code_o,
    output logic [PFN_W-1:0]  pfn_o,
    output logic [ATTR_W-1:0] attr_o,
    output logic              mem_req_valid_o,
    input  logic              mem_req_ready_i,
    output logic [PA_W-1:0]   mem_req_addr_o,
    output logic              mem_req_nocache_o,
    input  logic              mem_rsp_valid_i,
    input  logic [DESC_W-1:0] mem_rsp_data_i
);
    walk_st_e          st;
    flt_e              code;
    desc_t             rsp_desc;
    logic              start_ok;
    logic [VA_W-1:0]   va_q;
    logic [PA_W-1:0]   base_q;
    logic [PFN_W-1:0]  pt_frame_q;

    assign rsp_desc = desc_t'(mem_rsp_data_i);
    assign start_ok = walk_req_i && blk_miss_i && pg_miss_i && (st == ST_IDLE);

    tw_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start_ok  (start_ok),
        .req_ready (mem_req_ready_i),
        .rsp_valid (mem_rsp_valid_i),
        .rsp_ok    (rsp_desc.ok),
        .st        (st)
    );

    tw_result u_res (
        .clk        (clk),
        .rst        (rst),
        .start_ok   (start_ok),
        .st         (st),
        .rsp_valid  (mem_rsp_valid_i),
        .rsp_desc   (rsp_desc),
        .va_in      (va_i),
        .base_in    (seg_base_i),
        .va_q       (va_q),
        .base_q     (base_q),
        .pt_frame_q (pt_frame_q),
        .pfn_q      (pfn_o),
        .attr_q     (attr_o),
        .code_q     (code)
    );

    tw_addr u_addr (
        .st       (st),
        .va       (va_q),
        .seg_base (base_q),
        .pt_frame (pt_frame_q),
        .addr     (mem_req_addr_o)
    );

    assign busy_o            = (st != ST_IDLE);
    assign mem_req_valid_o   = (st == ST_SEG_REQ) || (st == ST_PG_REQ);
    assign mem_req_nocache_o = 1'b1;
    assign done_o            = (st == ST_FIN) && (code == FLT_NONE);
    assign fault_o           = (st == ST_FIN) && (code != FLT_NONE);
    assign fault_code_o      = code;
endmodule

// File: rtl/table_walker_chk.sv
module table_walker_chk (
    input logic        clk,
    input logic        rst,
    input logic        walk_req_i,
    input logic        blk_miss_i,
    input logic        pg_miss_i,
    input logic        busy_o,
    input logic        done_o,
    input logic        fault_o,
    input logic [1:0]  fault_code_o,
    input logic        mem_req_valid_o,
    input logic        mem_req_ready_i,
    input logic [31:0] mem_req_addr_o
);
    // R1: an accepted request makes the walker busy in the next cycle
    p_accept_busy_r1: assert property (@(posedge clk) disable iff (rst)
        (walk_req_i && blk_miss_i && pg_miss_i && !busy_o) |=> busy_o);

    // R1 and R12: without an accepted request an idle walker stays idle
    p_idle_holds_r12: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !(walk_req_i && blk_miss_i && pg_miss_i)) |=> !busy_o);

    // R2: the result pulses fall inside the busy window
    p_pulse_in_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (done_o || fault_o) |-> busy_o);

    // R2: busy drops only right after a result pulse
    p_busy_end_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> $past(done_o || fault_o));

    // R7: a pending request holds its address until it is accepted
    p_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

    // R8 and R9: a fault always carries a non-zero code
    p_fault_code_r8: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> (fault_code_o != 2'd0) && !done_o);

    // R10: success carries code zero and is a single-cycle pulse
    p_done_clean_r10: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (fault_code_o == 2'd0) ##1 !done_o);

    // R2: the walker never requests memory while idle
    p_req_needs_busy_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid_o |-> busy_o);
endmodule

bind table_walker table_walker_chk u_chk (.*);

// File: tb/table_walker_test.sv
`timescale 1ns/1ps
module table_walker_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        walk_req_i = 1'b0, blk_miss_i = 1'b0, pg_miss_i = 1'b0;
    logic [31:0] va_i = '0, seg_base_i = '0;
    logic        busy_o, done_o, fault_o;
    logic [1:0]  fault_code_o;
    logic [19:0] pfn_o;
    logic [10:0] attr_o;
    logic        mem_req_valid_o, mem_req_nocache_o;
    logic        mem_req_ready_i = 1'b0;
    logic [31:0] mem_req_addr_o;
    logic        mem_rsp_valid_i = 1'b0;
    logic [31:0] mem_rsp_data_i = '0;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    table_walker uut (.*);

    typedef struct packed {
        logic [31:0] va;
        logic [31:0] base;
        logic [31:0] sd;
        logic [31:0] pd;
        logic [3:0]  rdy;
        logic [3:0]  rsp;
        logic        dup;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{32'h0040_1ABC, 32'h0001_0000, 32'h0002_0001, 32'hABCD_E0F3, 4'd0, 4'd0, 1'b0},
        '{32'hFFFF_F123, 32'h8000_0000, 32'h1234_5001, 32'h0000_1FFF, 4'd2, 4'd3, 1'b0},
        '{32'h1234_5678, 32'h0000_4000, 32'h0000_5000, 32'hFFFF_FFFF, 4'd1, 4'd0, 1'b0},
        '{32'h0000_0000, 32'h0000_0000, 32'h0000_3001, 32'hFFFF_FFFE, 4'd0, 4'd5, 1'b0},
        '{32'h0080_2000, 32'h0000_0100, 32'h7777_7001, 32'h5555_5555, 4'd3, 4'd2, 1'b1},
        '{32'h0C00_3000, 32'hFFF0_0000, 32'h0003_0FFF, 32'h0000_0001, 4'd0, 4'd1, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_walk(input vec_t v);
        logic [31:0] exp_seg, exp_pg;
        logic [31:0] addrs [2];
        logic [1:0]  exp_code;
        int reads = 0, rcnt, dcnt, exp_reads;
        bit pend = 0, nc_ok = 1, ended = 0;
        logic got_done = 0, got_fault = 0;
        logic [1:0]  got_code = '0;
        logic [19:0] got_pfn = '0;
        logic [10:0] got_attr = '0;

        exp_seg   = v.base + {20'b0, v.va[31:22], 2'b00};
        exp_pg    = {v.sd[31:12], 12'h000} + {20'b0, v.va[21:12], 2'b00};
        exp_code  = !v.sd[0] ? 2'd1 : (!v.pd[0] ? 2'd2 : 2'd0);
        exp_reads = v.sd[0] ? 2 : 1;
        addrs[0] = '0; addrs[1] = '0;
        rcnt = v.rdy;

        @(negedge clk);
        walk_req_i = 1; blk_miss_i = 1; pg_miss_i = 1;
        va_i = v.va; seg_base_i = v.base;
        @(negedge clk);
        walk_req_i = v.dup;
        va_i = ~v.va; seg_base_i = ~v.base;
        chk(busy_o === 1'b1, "R2 busy after accept", 32'(busy_o), 32'd1);
        for (int i = 0; i < 300; i++) begin
            mem_req_ready_i = 0; mem_rsp_valid_i = 0;
            if (done_o || fault_o) begin
                got_done = done_o; got_fault = fault_o;
                got_code = fault_code_o; got_pfn = pfn_o; got_attr = attr_o;
                chk(busy_o === 1'b1, "R2 busy during result", 32'(busy_o), 32'd1);
                walk_req_i = 0;
                ended = 1;
                break;
            end
            if (pend) begin
                if (dcnt == 0) begin
                    mem_rsp_valid_i = 1;
                    mem_rsp_data_i  = (reads == 1) ? v.sd : ((reads == 2) ? v.pd : 32'hDEAD_BEEF);
                    pend = 0;
                end else dcnt--;
            end else if (mem_req_valid_o) begin
                if (rcnt == 0) begin
                    mem_req_ready_i = 1;
                    if (reads < 2) addrs[reads] = mem_req_addr_o;
                    if (mem_req_nocache_o !== 1'b1) nc_ok = 0;
                    reads++;
                    pend = 1; dcnt = v.rsp; rcnt = v.rdy;
                end else rcnt--;
            end
            @(negedge clk);
        end
        chk(ended, "watchdog walk finished", 32'(ended), 32'd1);
        chk(reads == exp_reads, "R5 read count", reads, exp_reads);
        chk(addrs[0] == exp_seg, "R3 segment descriptor address", addrs[0], exp_seg);
        if (exp_reads == 2)
            chk(addrs[1] == exp_pg, "R4 page descriptor address", addrs[1], exp_pg);
        chk(nc_ok, "R6 cache-inhibit mark", 32'(nc_ok), 32'd1);
        chk(got_code == exp_code, "R8 R9 R10 fault code", 32'(got_code), 32'(exp_code));
        chk(got_done == (exp_code == 0), "R10 done pulse", 32'(got_done), 32'(exp_code == 0));
        chk(got_fault == (exp_code != 0), "R8 R9 fault pulse", 32'(got_fault), 32'(exp_code != 0));
        if (exp_code == 0) begin
            chk(got_pfn == v.pd[31:12], "R10 frame number", 32'(got_pfn), 32'(v.pd[31:12]));
            chk(got_attr == v.pd[11:1], "R10 attributes", 32'(got_attr), 32'(v.pd[11:1]));
        end
        if (v.dup) chk(reads == exp_reads && addrs[0] == exp_seg, "R11 request during walk ignored", addrs[0], exp_seg);
        @(negedge clk);
        chk(busy_o === 1'b0 && done_o === 1'b0 && fault_o === 1'b0, "R2 idle after result", 32'(busy_o), 32'd0);
    endtask

    task automatic try_hit(input logic bm, input logic pm);
        bit seen = 0;
        @(negedge clk);
        walk_req_i = 1; blk_miss_i = bm; pg_miss_i = pm; va_i = 32'h1111_1000;
        @(negedge clk);
        walk_req_i = 0;
        for (int i = 0; i < 4; i++) begin
            if (busy_o || mem_req_valid_o) seen = 1;
            @(negedge clk);
        end
        chk(!seen, "R1 hit blocks walk", 32'(seen), 32'd0);
    endtask

    initial begin
        #(5.0 * 200000);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(busy_o === 0 && mem_req_valid_o === 0 && done_o === 0 && fault_o === 0,
            "R2 reset state", {28'b0, busy_o, mem_req_valid_o, done_o, fault_o}, 32'd0);

        for (int k = 0; k < NV; k++) run_walk(VECS[k]);

        // R1: hits in either translation cache
        try_hit(1'b0, 1'b1);
        try_hit(1'b1, 1'b0);

        // R12: spurious response strobe while idle
        begin
            bit seen = 0;
            @(negedge clk);
            mem_rsp_valid_i = 1; mem_rsp_data_i = 32'h0000_0001;
            @(negedge clk);
            mem_rsp_valid_i = 0;
            for (int i = 0; i < 4; i++) begin
                if (busy_o || done_o || fault_o) seen = 1;
                @(negedge clk);
            end
            chk(!seen, "R12 idle response ignored", 32'(seen), 32'd0);
        end

        // back-to-back walks after the idle checks
        run_walk(VECS[1]);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule